// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Walker

This block walks a table of 16-byte scatter-gather descriptors that sits in memory directly after a command header. It is started with the command base address, the header length in bytes, the transfer direction and the total byte count. It reads each descriptor as two 8-byte words over a single-outstanding memory read port, and passes one address/length segment at a time to a data mover over a valid/ready handshake. It stops when the requested byte count is used up or when it reaches the descriptor that carries the terminator flag.

A descriptor is two little-endian 64-bit words. The word at offset 0 holds the buffer address. The word at offset 8 holds the byte count in bits 31:0 and the flags in bits 63:32. Bit 63 of that word (flag bit 31) is the terminator. If the chain ends while bytes are still owed, the walker reports an underrun or overrun code that depends on the direction. Misaligned bases are refused before any memory access is made.

Top module: `sg_chain_walker`

## Requirements
- R1: When a start arrives with `cmd_base_i[2:0]` not zero, the block makes no memory request and pulses `done_o` on the next cycle with code 24. This check takes priority over every other outcome.
- R2: When the command base is aligned but the table base `cmd_base_i + hdr_bytes_i` has `[2:0]` not zero, the block makes no request and finishes with code 16.
- R3: The first read request goes to the table base. Reads then advance by 8 bytes each. Every descriptor is read as an address word followed by a control word, and bit 63 of the control word marks the terminator.
- R4: A read request holds `rd_req_valid_o` and its address steady until `rd_req_ready_i` accepts it. No new request is issued until the previous response has arrived.
- R5: Each segment carries the descriptor address and the length min(count, bytes remaining). It is held steady until `seg_ready_i` accepts it. No read request is made while a segment is being offered.
- R6: A descriptor whose clamped length is zero produces no segment.
- R7: When the bytes remaining reach zero, the block finishes with code 0 and fetches nothing more, even if the current descriptor is not the terminator.
- R8: If the terminator has been handled and bytes remain, with `dir_wr_i`=1 (data flows to the device), the block finishes with code 7.
- R9: The same situation with `dir_wr_i`=0 (data flows from the device) finishes with code 8.
- R10: A start with aligned bases and a total of zero finishes on the next cycle with code 0 and no request.
- R11: `done_o` is a single-cycle pulse. `err_code_o` changes only in the cycle of that pulse and otherwise holds its value. A start that arrives while `busy_o` is high is ignored.
- R12: After reset, `busy_o`, `done_o`, `rd_req_valid_o`, `seg_valid_o` and `err_code_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a walk; sampled only while idle |
| cmd_base_i | input | ADDR_W | Command header byte address |
| hdr_bytes_i | input | OFS_W | Header length; the descriptor table starts right after it |
| dir_wr_i | input | 1 | 1 = data goes to the device, 0 = data comes from it |
| total_i | input | LEN_W | Total bytes to move |
| busy_o | output | 1 | A walk is in progress |
| rd_req_valid_o | output | 1 | Memory read request valid |
| rd_req_ready_i | input | 1 | Memory read request accepted |
| rd_req_addr_o | output | ADDR_W | Byte address of the 8-byte word to read |
| rd_rsp_valid_i | input | 1 | Read data valid |
| rd_rsp_data_i | input | 64 | Read data word |
| seg_valid_o | output | 1 | Segment offered to the data mover |
| seg_ready_i | input | 1 | Segment accepted |
| seg_addr_o | output | ADDR_W | Segment buffer address |
| seg_len_o | output | LEN_W | Segment length in bytes |
| done_o | output | 1 | One-cycle completion pulse |
| err_code_o | output | 6 | Result code of the last walk |

## Verification
Two functions can land in the same step: using up the byte count, and reaching the terminator descriptor. The bench provokes this coincidence with a chain whose sum equals the total exactly, and it also runs totals that fall short of the sum and totals that exceed it. When count and terminator meet on the same segment, the byte count must win and the result code must be 0. When bytes are still owed at the terminator, the code must be the underrun or overrun value for the chosen direction. The bench judges each case by the segment stream, the number of read requests, and the code reported with the done pulse.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
    localparam int CODE_W = 6;

    localparam logic [CODE_W-1:0] CODE_OK        = 6'd0;
    localparam logic [CODE_W-1:0] CODE_SHORT_WR  = 6'd7;
    localparam logic [CODE_W-1:0] CODE_SHORT_RD  = 6'd8;
    localparam logic [CODE_W-1:0] CODE_TBL_ALIGN = 6'd16;
    localparam logic [CODE_W-1:0] CODE_CMD_ALIGN = 6'd24;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_RSP,
        ST_SEG
    } walk_st_e;

    typedef enum logic [1:0] {
        LV_GO,
        LV_FAIL,
        LV_EMPTY
    } launch_e;
endpackage

// File: rtl/sgw_launch_check.sv
module sgw_launch_check
    import sgw_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int OFS_W  = 8,
    parameter int LEN_W  = 32
) (
    input  logic [ADDR_W-1:0] cmd_base_i,
    input  logic [OFS_W-1:0]  hdr_bytes_i,
    input  logic [LEN_W-1:0]  total_i,
    output logic [ADDR_W-1:0] tbl_base_o,
    output launch_e           verdict_o,
    output logic [CODE_W-1:0] code_o
);
    localparam int ALIGN_BITS = 3;

    always_comb begin
        tbl_base_o = cmd_base_i + ADDR_W'(hdr_bytes_i);
        verdict_o  = LV_GO;
        code_o     = CODE_OK;
        // header alignment outranks table alignment
        if (cmd_base_i[ALIGN_BITS-1:0] != '0) begin
            verdict_o = LV_FAIL;
            code_o    = CODE_CMD_ALIGN;
        end else if (tbl_base_o[ALIGN_BITS-1:0] != '0) begin
            verdict_o = LV_FAIL;
            code_o    = CODE_TBL_ALIGN;
        end else if (total_i == '0) begin
            verdict_o = LV_EMPTY;
        end
    end
endmodule

// File: rtl/sgw_beat_decode.sv
module sgw_beat_decode #(
    parameter int ADDR_W = 64,
    parameter int LEN_W  = 32
) (
    input  logic [63:0]       beat_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [LEN_W-1:0]  cnt_o,
    output logic              last_o
);
    localparam int CNT_BITS  = 32;
    localparam int LAST_BIT  = 63;

    generate
        if (ADDR_W > 64) begin : g_addr_wide
            assign addr_o = {{(ADDR_W-64){1'b0}}, beat_i};
        end else begin : g_addr_narrow
            assign addr_o = beat_i[ADDR_W-1:0];
        end
        if (LEN_W > CNT_BITS) begin : g_cnt_wide
            assign cnt_o = {{(LEN_W-CNT_BITS){1'b0}}, beat_i[CNT_BITS-1:0]};
        end else begin : g_cnt_narrow
            assign cnt_o = beat_i[LEN_W-1:0];
        end
    endgenerate

    assign last_o = beat_i[LAST_BIT];
endmodule

// File: rtl/sgw_len_clamp.sv
module sgw_len_clamp #(
    parameter int LEN_W = 32
) (
    input  logic [LEN_W-1:0] cnt_i,
    input  logic [LEN_W-1:0] remaining_i,
    output logic [LEN_W-1:0] take_o,
    output logic             take_zero_o
);
    always_comb begin
        take_o      = (cnt_i < remaining_i) ? cnt_i : remaining_i;
        take_zero_o = (take_o == '0);
    end
endmodule

// File: rtl/sg_chain_walker.sv
module sg_chain_walker
    import sgw_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int OFS_W  = 8,
    parameter int LEN_W  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [ADDR_W-1:0]   cmd_base_i,
    input  logic [OFS_W-1:0]    hdr_bytes_i,
    input  logic                dir_wr_i,
    input  logic [LEN_W-1:0]    total_i,
    output logic                busy_o,
    output logic                rd_req_valid_o,
    input  logic                rd_req_ready_i,
    output logic [ADDR_W-1:0]   rd_req_addr_o,
    input  logic                rd_rsp_valid_i,
    input  logic [63:0]         rd_rsp_data_i,
    output logic                seg_valid_o,
    input  logic                seg_ready_i,
    output logic [ADDR_W-1:0]   seg_addr_o,
    output logic [LEN_W-1:0]    seg_len_o,
    output logic                done_o,
    output logic [CODE_W-1:0]   err_code_o
);
    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(8);

    typedef struct packed {
        walk_st_e           st;
        logic [ADDR_W-1:0]  fetch_addr;
        logic               beat;
        logic [ADDR_W-1:0]  seg_addr;
        logic [LEN_W-1:0]   seg_len;
        logic               last;
        logic [LEN_W-1:0]   remaining;
        logic               dir_wr;
        logic               done;
        logic [CODE_W-1:0]  code;
    } walk_regs_t;

    walk_regs_t q, d;

    logic [ADDR_W-1:0] tbl_base;
    launch_e           verdict;
    logic [CODE_W-1:0] launch_code;
    logic [ADDR_W-1:0] dec_addr;
    logic [LEN_W-1:0]  dec_cnt;
    logic              dec_last;
    logic [LEN_W-1:0]  take;
    logic              take_zero;
    logic [LEN_W-1:0]  rem_after;
    logic [CODE_W-1:0] short_code;

    sgw_launch_check #(
        .ADDR_W (ADDR_W),
        .OFS_W  (OFS_W),
        .LEN_W  (LEN_W)
    ) u_launch (
        .cmd_base_i  (cmd_base_i),
        .hdr_bytes_i (hdr_bytes_i),
        .total_i     (total_i),
        .tbl_base_o  (tbl_base),
        .verdict_o   (verdict),
        .code_o      (launch_code)
    );

    sgw_beat_decode #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_decode (
        .beat_i (rd_rsp_data_i),
        .addr_o (dec_addr),
        .cnt_o  (dec_cnt),
        .last_o (dec_last)
    );

    sgw_len_clamp #(
        .LEN_W (LEN_W)
    ) u_clamp (
        .cnt_i       (dec_cnt),
        .remaining_i (q.remaining),
        .take_o      (take),
        .take_zero_o (take_zero)
    );

    assign rem_after  = q.remaining - q.seg_len;
    assign short_code = q.dir_wr ? CODE_SHORT_WR : CODE_SHORT_RD;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    unique case (verdict)
                        LV_FAIL: begin
                            d.done = 1'b1;
                            d.code = launch_code;
                        end
                        LV_EMPTY: begin
                            d.done = 1'b1;
                            d.code = CODE_OK;
                        end
                        default: begin
                            d.st         = ST_REQ;
                            d.fetch_addr = tbl_base;
                            d.beat       = 1'b0;
                            d.remaining  = total_i;
                            d.dir_wr     = dir_wr_i;
                        end
                    endcase
                end
            end
            ST_REQ: begin
                if (rd_req_ready_i) begin
                    d.st = ST_RSP;
                end
            end
            ST_RSP: begin
                if (rd_rsp_valid_i) begin
                    d.fetch_addr = q.fetch_addr + WORD_STEP;
                    if (!q.beat) begin
                        d.seg_addr = dec_addr;
                        d.beat     = 1'b1;
                        d.st       = ST_REQ;
                    end else begin
                        d.beat    = 1'b0;
                        d.seg_len = take;
                        d.last    = dec_last;
                        if (!take_zero) begin
                            d.st = ST_SEG;
                        end else if (dec_last) begin
                            d.st   = ST_IDLE;
                            d.done = 1'b1;
                            d.code = short_code;
                        end else begin
                            d.st = ST_REQ;
                        end
                    end
                end
            end
            ST_SEG: begin
                if (seg_ready_i) begin
                    d.remaining = rem_after;
                    if (rem_after == '0) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                        d.code = CODE_OK;
                    end else if (q.last) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                        d.code = short_code;
                    end else begin
                        d.st = ST_REQ;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign busy_o         = (q.st != ST_IDLE);
    assign rd_req_valid_o = (q.st == ST_REQ);
    assign rd_req_addr_o  = q.fetch_addr;
    assign seg_valid_o    = (q.st == ST_SEG);
    assign seg_addr_o     = q.seg_addr;
    assign seg_len_o      = q.seg_len;
    assign done_o         = q.done;
    assign err_code_o     = q.code;
endmodule

// File: rtl/sgw_checker.sv
module sgw_checker #(
    parameter int ADDR_W = 64,
    parameter int LEN_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              rd_req_valid_o,
    input logic              rd_req_ready_i,
    input logic [ADDR_W-1:0] rd_req_addr_o,
    input logic              seg_valid_o,
    input logic              seg_ready_i,
    input logic [ADDR_W-1:0] seg_addr_o,
    input logic [LEN_W-1:0]  seg_len_o,
    input logic              done_o,
    input logic [5:0]        err_code_o
);
    a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid_o && !rd_req_ready_i |=> rd_req_valid_o && $stable(rd_req_addr_o));

    a_r3_req_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid_o |-> rd_req_addr_o[2:0] == 3'd0);

    a_r5_seg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid_o && !seg_ready_i |=> seg_valid_o && $stable(seg_addr_o) && $stable(seg_len_o));

    a_r5_no_fetch_while_offering: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req_valid_o && seg_valid_o));

    a_r6_nonzero_seg: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid_o |-> seg_len_o != '0);

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r11_code_held: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |=> done_o || $stable(err_code_o));

    a_r11_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    a_r12_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !rd_req_valid_o && !seg_valid_o);
endmodule

bind sg_chain_walker sgw_checker #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W)
) u_sgw_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .busy_o         (busy_o),
    .rd_req_valid_o (rd_req_valid_o),
    .rd_req_ready_i (rd_req_ready_i),
    .rd_req_addr_o  (rd_req_addr_o),
    .seg_valid_o    (seg_valid_o),
    .seg_ready_i    (seg_ready_i),
    .seg_addr_o     (seg_addr_o),
    .seg_len_o      (seg_len_o),
    .done_o         (done_o),
    .err_code_o     (err_code_o)
);

// File: tb/sg_chain_walker_tb.sv
module sg_chain_walker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] cmd_base_i = '0;
    logic [7:0]  hdr_bytes_i = 8'd32;
    logic        dir_wr_i = 1'b0;
    logic [31:0] total_i = '0;
    logic        busy_o;
    logic        rd_req_valid_o;
    logic        rd_req_ready_i = 1'b0;
    logic [63:0] rd_req_addr_o;
    logic        rd_rsp_valid_i = 1'b0;
    logic [63:0] rd_rsp_data_i = '0;
    logic        seg_valid_o;
    logic        seg_ready_i = 1'b0;
    logic [63:0] seg_addr_o;
    logic [31:0] seg_len_o;
    logic        done_o;
    logic [5:0]  err_code_o;

    always #10 clk = ~clk;

    sg_chain_walker u_dut (
        .clk (clk), .rst_n (rst_n), .start_i (start_i),
        .cmd_base_i (cmd_base_i), .hdr_bytes_i (hdr_bytes_i),
        .dir_wr_i (dir_wr_i), .total_i (total_i), .busy_o (busy_o),
        .rd_req_valid_o (rd_req_valid_o), .rd_req_ready_i (rd_req_ready_i),
        .rd_req_addr_o (rd_req_addr_o), .rd_rsp_valid_i (rd_rsp_valid_i),
        .rd_rsp_data_i (rd_rsp_data_i), .seg_valid_o (seg_valid_o),
        .seg_ready_i (seg_ready_i), .seg_addr_o (seg_addr_o),
        .seg_len_o (seg_len_o), .done_o (done_o), .err_code_o (err_code_o)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [63:0] mem [0:511];
    logic [63:0] exp_addr_q [$];
    logic [31:0] exp_len_q [$];
    int          exp_reqs;
    int          exp_code;
    int          req_cnt;
    logic [63:0] first_req_addr;
    int          pend = 0;
    logic [63:0] pend_data = '0;
    logic [7:0]  lfsr = 8'hA5;
    bit          done_seen = 0;
    int          got_code = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic put_desc(input int tbl, input int idx, input logic [63:0] a,
                            input logic [31:0] cnt, input bit last);
        mem[(tbl + idx*16) / 8]     = a;
        mem[(tbl + idx*16) / 8 + 1] = {last, 31'd0, cnt};
    endtask

    // behavioural reference of the walk (R3, R5-R10)
    task automatic build_expect(input logic [63:0] cmd, input int hdr,
                                input int total, input bit dwr);
        int tbl;
        int rem;
        exp_addr_q.delete();
        exp_len_q.delete();
        exp_reqs = 0;
        tbl = int'(cmd) + hdr;
        if (cmd[2:0] != 0) begin exp_code = 24; return; end
        if (tbl % 8 != 0) begin exp_code = 16; return; end
        if (total == 0) begin exp_code = 0; return; end
        rem = total;
        for (int i = 0; i < 64; i++) begin
            logic [63:0] a;
            logic [63:0] c;
            int len;
            a = mem[(tbl + i*16) / 8];
            c = mem[(tbl + i*16) / 8 + 1];
            exp_reqs += 2;
            len = (int'(c[31:0]) < rem) ? int'(c[31:0]) : rem;
            if (len > 0) begin
                exp_addr_q.push_back(a);
                exp_len_q.push_back(32'(len));
            end
            rem -= len;
            if (rem == 0) begin exp_code = 0; return; end
            if (c[63]) begin exp_code = dwr ? 7 : 8; return; end
        end
    endtask

    // per-clock responder and comparison, away from the active edge
    always @(negedge clk) begin
        cycles++;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        rd_rsp_valid_i = 1'b0;
        if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                rd_rsp_valid_i = 1'b1;
                rd_rsp_data_i  = pend_data;
            end
        end
        rd_req_ready_i = lfsr[0] | lfsr[3];
        if (rst_n && rd_req_valid_o && rd_req_ready_i) begin
            req_cnt++;
            if (req_cnt == 1) first_req_addr = rd_req_addr_o;
            pend      = 1 + int'(lfsr[2]);
            pend_data = mem[rd_req_addr_o[11:3]];
        end
        seg_ready_i = lfsr[1] | lfsr[4];
        if (rst_n && seg_valid_o && seg_ready_i) begin
            if (exp_addr_q.size() == 0) begin
                chk(1'b0, "R5 unexpected segment", seg_addr_o, 64'd0);
            end else begin
                chk(seg_addr_o == exp_addr_q[0], "R5 segment address", seg_addr_o, exp_addr_q[0]);
                chk(seg_len_o == exp_len_q[0], "R5 segment length", 64'(seg_len_o), 64'(exp_len_q[0]));
                void'(exp_addr_q.pop_front());
                void'(exp_len_q.pop_front());
            end
        end
        if (rst_n && done_o) begin
            done_seen = 1;
            got_code  = int'(err_code_o);
        end
    end

    task automatic run_case(input string tag, input logic [63:0] cmd, input int hdr,
                            input int total, input bit dwr, input bit poke);
        int waited;
        int n_left;
        build_expect(cmd, hdr, total, dwr);
        @(negedge clk);
        req_cnt     = 0;
        done_seen   = 0;
        cmd_base_i  = cmd;
        hdr_bytes_i = 8'(hdr);
        total_i     = 32'(total);
        dir_wr_i    = dwr;
        start_i     = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            repeat (4) @(negedge clk);
            // R11: restart attempt while busy must change nothing
            chk(busy_o == 1'b1, "R11 busy during walk", 64'(busy_o), 64'd1);
            cmd_base_i = 64'h105;
            start_i    = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        waited = 0;
        while (!done_seen && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
        chk(done_seen == 1, {tag, " done reached"}, 64'(done_seen), 64'd1);
        chk(got_code == exp_code, {tag, " result code"}, 64'(got_code), 64'(exp_code));
        chk(req_cnt == exp_reqs, {tag, " read request count"}, 64'(req_cnt), 64'(exp_reqs));
        n_left = exp_addr_q.size();
        chk(n_left == 0, {tag, " segments missing"}, 64'(n_left), 64'd0);
        if (exp_reqs > 0)
            chk(first_req_addr == cmd + 64'(hdr), "R3 first fetch at table base",
                first_req_addr, cmd + 64'(hdr));
        repeat (3) @(negedge clk);
        chk(err_code_o == 6'(exp_code), "R11 code held after done", 64'(err_code_o), 64'(exp_code));
    endtask

    initial begin : watchdog
        while (cycles < 150000) @(negedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < 512; i++) mem[i] = '0;
        // chain behind header at 0x100
        put_desc(32'h120, 0, 64'h1000, 100, 0);
        put_desc(32'h120, 1, 64'h2000, 200, 0);
        put_desc(32'h120, 2, 64'h3000, 50, 1);
        // chain with a zero-length middle entry behind 0x300
        put_desc(32'h320, 0, 64'h4000, 64, 0);
        put_desc(32'h320, 1, 64'h5000, 0, 0);
        put_desc(32'h320, 2, 64'h6000, 32, 1);
        // zero-length terminator behind 0x400
        put_desc(32'h420, 0, 64'h7000, 16, 0);
        put_desc(32'h420, 1, 64'h8000, 0, 1);
        // single large entry behind 0x500
        put_desc(32'h520, 0, 64'h9000, 1000, 1);

        repeat (3) @(negedge clk);
        // R12: reset state
        chk(busy_o == 0, "R12 busy after reset", 64'(busy_o), 0);
        chk(done_o == 0, "R12 done after reset", 64'(done_o), 0);
        chk(rd_req_valid_o == 0, "R12 request after reset", 64'(rd_req_valid_o), 0);
        chk(seg_valid_o == 0, "R12 segment after reset", 64'(seg_valid_o), 0);
        chk(err_code_o == 0, "R12 code after reset", 64'(err_code_o), 0);
        rst_n = 1'b1;

        run_case("R7 exact fit on terminator", 64'h100, 32, 350, 1'b1, 1'b0);
        run_case("R7 ends before terminator", 64'h100, 32, 250, 1'b0, 1'b0);
        run_case("R8 write underrun", 64'h100, 32, 400, 1'b1, 1'b0);
        run_case("R9 read overrun", 64'h100, 32, 400, 1'b0, 1'b0);
        run_case("R1 misaligned header", 64'h104, 32, 100, 1'b1, 1'b0);
        run_case("R2 misaligned table", 64'h200, 36, 100, 1'b1, 1'b0);
        run_case("R6 zero-length entry skipped", 64'h300, 32, 96, 1'b0, 1'b0);
        run_case("R10 empty transfer", 64'h100, 32, 0, 1'b1, 1'b0);
        run_case("R9 zero-length terminator", 64'h400, 32, 32, 1'b0, 1'b0);
        run_case("R11 restart while busy ignored", 64'h100, 32, 350, 1'b1, 1'b1);
        run_case("R5 clamp to remaining", 64'h500, 32, 10, 1'b0, 1'b0);
        run_case("R1 misaligned beats table check", 64'h101, 7, 8, 1'b0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule